// File: doc/BRIEF.md
# Vector Block Header Decoder

This block reads the leading halfword of a variable-length vector block instruction, plus the optional 16-bit vector-length word that may follow it. From the prefix it derives the layout of the whole block. That layout covers how many register-context and predicate-context entries are present, how wide each entry is, where each section starts in bits, where the opcode area begins in halfwords, and how long the full instruction is. A layout whose tables would spill past the declared instruction length is flagged illegal.

When the vector-length word is present, the block also holds the architectural VL and MVL registers and updates them. One mode clamps a requested length to the current maximum. Another sets the maximum and the length together. A third hands the request to an external set-length unit untouched. The fourth code is reserved and must be all zero. An optional integer destination register receives the new length.

The caller drives only prefix bits 15:7, because the low seven bits are the standard length-encoding opcode and do not affect this block. One header is accepted per `hdr_valid` pulse. All results appear one cycle later, alongside an `out_valid` pulse.

Top module: `vblk_hdr_decode`

## Requirements
- R1: The register entry count comes from prefix bits 11:10 (code 0..3). With prefix bit 7 = 1 (16-bit entries) the count is 0,1,2,4. With bit 7 = 0 (8-bit entries) the count is 0,2,4,8.
- R2: When prefix bit 9 = 1 the predicate entry count equals the register count. When bit 9 = 0 it is half the register count, rounded up. Prefix bit 8 = 1 selects 16-bit predicate entries and 0 selects 8-bit entries.
- R3: Bit offsets from the block start follow the section order prefix, length word, register entries, predicate entries. `reg_off_bits` is 32 when prefix bit 15 = 1 and 16 otherwise. `pred_off_bits` is `reg_off_bits` plus the register section size.
- R4: `op_off_hw` is the end of the predicate section in bits, divided by 16 and rounded up.
- R5: `instr_len_bits` is 80 + 16 x IL, where IL is prefix bits 14:12.
- R6: `illegal` is raised when `op_off_hw` exceeds `instr_len_bits`/16. An opcode offset exactly equal to the length is legal.
- R7: The length word is laid out as mode[15:14], dest[13:10], imm[9:0]. Mode 00 sets VL to min(imm, MVL) and leaves MVL unchanged.
- R8: Mode 10 sets both MVL and VL to imm.
- R9: In modes 00 and 10, a nonzero dest field d produces a one-cycle `rd_we` with `rd_num` = d+8 and `rd_val` = the new VL. A dest field of zero names x0, and no write is made.
- R10: Mode 01 leaves VL and MVL unchanged and pulses `setvl_req` with `setvl_imm` = imm. `setvl_rd` is d+8, or 0 when d = 0.
- R11: Mode 11 with every other bit of the length word zero is legal and has no effect. Mode 11 with any nonzero bit raises `illegal`.
- R12: When prefix bit 15 = 0, or when the header is illegal, the length word is ignored: VL, MVL, `rd_we` and `setvl_req` are untouched.
- R13: All outputs update on the edge that samples `hdr_valid`. `out_valid`, `rd_we` and `setvl_req` are single-cycle pulses. Reset gives VL = 0, MVL = `RST_MVL` (64 by default), and all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present this cycle |
| prefix_hi | input | 9 | Prefix bits 15:7 |
| vl_word | input | 16 | Optional vector-length word |
| out_valid | output | 1 | Decoded results valid |
| reg_wide | output | 1 | Register entries are 16-bit |
| pred_wide | output | 1 | Predicate entries are 16-bit |
| has_vl_word | output | 1 | Length word present |
| reg_cnt | output | 4 | Register entry count |
| pred_cnt | output | 4 | Predicate entry count |
| instr_len_bits | output | 8 | Total instruction length in bits |
| reg_off_bits | output | 9 | Register section bit offset |
| pred_off_bits | output | 9 | Predicate section bit offset |
| op_off_hw | output | 5 | Opcode area offset in halfwords |
| illegal | output | 1 | Malformed header |
| vl | output | 10 | Current vector length |
| mvl | output | 10 | Current maximum vector length |
| rd_we | output | 1 | Destination register write pulse |
| rd_num | output | 5 | Destination register number |
| rd_val | output | 10 | Value written to the destination |
| setvl_req | output | 1 | Forward to external set-length unit |
| setvl_rd | output | 5 | Forwarded destination register |
| setvl_imm | output | 10 | Forwarded requested length |

## Verification
The layout is swept over every combination of entry widths, count codes, the predicate ratio bit, presence of the length word and every IL value. This separates the two count encodings, the odd-count rounding of predicates and the halfword rounding of the opcode offset. Directed length words then tell the clamp, set-both, forward and reserved modes apart. They use requests above and below MVL, a zero and a nonzero destination, and a reserved word with a stray bit in the dest field or in the immediate. A table that exactly fills the instruction is decoded next to one that overruns by a halfword. Headers that are absent or illegal each carry a length word that would otherwise change VL, so that the ignore path is visible at the ports.

// File: rtl/vblk_pkg.sv
package vblk_pkg;

  localparam int HW_BITS  = 16;
  localparam int BASE_HW  = 5;
  localparam int IMM_W    = 10;
  localparam int DEST_W   = 4;
  localparam int RD_W     = 5;
  localparam int CNT_W    = 4;
  localparam int OFF_W    = 9;
  localparam int HWU_W    = 5;
  localparam int LEN_W    = 8;
  localparam int DEST_BASE = 8;

  typedef enum logic [1:0] {
    VM_CLAMP = 2'b00,
    VM_FWD   = 2'b01,
    VM_BOTH  = 2'b10,
    VM_RSVD  = 2'b11
  } vl_mode_e;

  typedef struct packed {
    logic        has_vl;
    logic [2:0]  il;
    logic [1:0]  rcode;
    logic        pp_full;
    logic        pred_wide;
    logic        reg_wide;
  } pfx_t;

  typedef struct packed {
    vl_mode_e              mode;
    logic [DEST_W-1:0]     dest;
    logic [IMM_W-1:0]      imm;
  } vlw_t;

  function automatic logic [CNT_W-1:0] f_reg_count(input logic [1:0] code, input logic wide);
    logic [CNT_W-1:0] n;
    if (code == 2'd0) begin
      n = '0;
    end else begin
      n = CNT_W'(1) << (code - 2'd1);
      if (!wide) n = n << 1;
    end
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] f_pred_count(input logic [CNT_W-1:0] rc, input logic full);
    return full ? rc : ((rc + CNT_W'(1)) >> 1);
  endfunction

  function automatic logic [OFF_W-1:0] f_sect_bits(input logic [CNT_W-1:0] cnt, input logic wide);
    return OFF_W'(cnt) << (wide ? 4 : 3);
  endfunction

  function automatic logic [HWU_W-1:0] f_ceil_hw(input logic [OFF_W-1:0] bits);
    logic [OFF_W:0] t;
    t = {1'b0, bits} + (OFF_W+1)'(HW_BITS - 1);
    return HWU_W'(t >> 4);
  endfunction

  function automatic logic [RD_W-1:0] f_dest_reg(input logic [DEST_W-1:0] d);
    return (d == '0) ? '0 : (RD_W'(d) + RD_W'(DEST_BASE));
  endfunction

endpackage

// File: rtl/vblk_layout.sv
module vblk_layout
  import vblk_pkg::*;
(
  input  pfx_t              pfx,
  output logic [CNT_W-1:0]  reg_cnt,
  output logic [CNT_W-1:0]  pred_cnt,
  output logic [OFF_W-1:0]  reg_off,
  output logic [OFF_W-1:0]  pred_off,
  output logic [HWU_W-1:0]  op_hw,
  output logic [LEN_W-1:0]  len_bits,
  output logic              overrun
);
  localparam logic [OFF_W-1:0] PFX_END = OFF_W'(HW_BITS);
  localparam logic [OFF_W-1:0] VLW_END = OFF_W'(2*HW_BITS);

  logic [OFF_W-1:0] op_bits;
  logic [HWU_W-1:0] len_hw;

  always_comb begin
    reg_cnt  = f_reg_count(pfx.rcode, pfx.reg_wide);
    pred_cnt = f_pred_count(reg_cnt, pfx.pp_full);
    reg_off  = pfx.has_vl ? VLW_END : PFX_END;
    pred_off = reg_off + f_sect_bits(reg_cnt, pfx.reg_wide);
    op_bits  = pred_off + f_sect_bits(pred_cnt, pfx.pred_wide);
    op_hw    = f_ceil_hw(op_bits);
    len_hw   = HWU_W'(BASE_HW) + HWU_W'(pfx.il);
    len_bits = LEN_W'(len_hw) << 4;
    overrun  = op_hw > len_hw;
  end
endmodule

// File: rtl/vblk_vlmode.sv
module vblk_vlmode
  import vblk_pkg::*;
(
  input  vlw_t              vw,
  input  logic [IMM_W-1:0]  cur_vl,
  input  logic [IMM_W-1:0]  cur_mvl,
  output logic [IMM_W-1:0]  nxt_vl,
  output logic [IMM_W-1:0]  nxt_mvl,
  output logic              dest_hit,
  output logic              fwd_hit,
  output logic [RD_W-1:0]   dest_reg,
  output logic              rsvd_bad
);
  always_comb begin
    nxt_vl   = cur_vl;
    nxt_mvl  = cur_mvl;
    dest_hit = 1'b0;
    fwd_hit  = 1'b0;
    dest_reg = f_dest_reg(vw.dest);
    rsvd_bad = 1'b0;
    unique case (vw.mode)
      VM_CLAMP: begin
        nxt_vl   = (vw.imm > cur_mvl) ? cur_mvl : vw.imm;
        dest_hit = (vw.dest != '0);
      end
      VM_BOTH: begin
        nxt_vl   = vw.imm;
        nxt_mvl  = vw.imm;
        dest_hit = (vw.dest != '0);
      end
      VM_FWD: begin
        fwd_hit = 1'b1;
      end
      VM_RSVD: begin
        rsvd_bad = ({vw.dest, vw.imm} != '0);
      end
    endcase
  end
endmodule

// File: rtl/vblk_hdr_decode.sv
module vblk_hdr_decode
  import vblk_pkg::*;
#(
  parameter int RST_MVL = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [8:0]        prefix_hi,
  input  logic [15:0]       vl_word,
  output logic              out_valid,
  output logic              reg_wide,
  output logic              pred_wide,
  output logic              has_vl_word,
  output logic [3:0]        reg_cnt,
  output logic [3:0]        pred_cnt,
  output logic [7:0]        instr_len_bits,
  output logic [8:0]        reg_off_bits,
  output logic [8:0]        pred_off_bits,
  output logic [4:0]        op_off_hw,
  output logic              illegal,
  output logic [9:0]        vl,
  output logic [9:0]        mvl,
  output logic              rd_we,
  output logic [4:0]        rd_num,
  output logic [9:0]        rd_val,
  output logic              setvl_req,
  output logic [4:0]        setvl_rd,
  output logic [9:0]        setvl_imm
);
  localparam logic [IMM_W-1:0] MVL_INIT = IMM_W'(RST_MVL);

  pfx_t pfx;
  vlw_t vw;
  assign pfx = pfx_t'(prefix_hi);
  assign vw  = vlw_t'(vl_word);

  logic [CNT_W-1:0] lay_rcnt, lay_pcnt;
  logic [OFF_W-1:0] lay_roff, lay_poff;
  logic [HWU_W-1:0] lay_ophw;
  logic [LEN_W-1:0] lay_len;
  logic             ev_overrun;

  vblk_layout i_layout (
    .pfx      (pfx),
    .reg_cnt  (lay_rcnt),
    .pred_cnt (lay_pcnt),
    .reg_off  (lay_roff),
    .pred_off (lay_poff),
    .op_hw    (lay_ophw),
    .len_bits (lay_len),
    .overrun  (ev_overrun)
  );

  logic [IMM_W-1:0] nxt_vl, nxt_mvl;
  logic             dest_hit, fwd_hit, ev_rsvd_bad;
  logic [RD_W-1:0]  dest_reg;

  vblk_vlmode i_vlmode (
    .vw       (vw),
    .cur_vl   (vl),
    .cur_mvl  (mvl),
    .nxt_vl   (nxt_vl),
    .nxt_mvl  (nxt_mvl),
    .dest_hit (dest_hit),
    .fwd_hit  (fwd_hit),
    .dest_reg (dest_reg),
    .rsvd_bad (ev_rsvd_bad)
  );

  // named events for the checker
  logic ev_illegal, ev_apply;
  assign ev_illegal = ev_overrun | (pfx.has_vl & ev_rsvd_bad);
  assign ev_apply   = hdr_valid & pfx.has_vl & ~ev_illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      reg_wide       <= 1'b0;
      pred_wide      <= 1'b0;
      has_vl_word    <= 1'b0;
      reg_cnt        <= '0;
      pred_cnt       <= '0;
      instr_len_bits <= '0;
      reg_off_bits   <= '0;
      pred_off_bits  <= '0;
      op_off_hw      <= '0;
      illegal        <= 1'b0;
      vl             <= '0;
      mvl            <= MVL_INIT;
      rd_we          <= 1'b0;
      rd_num         <= '0;
      rd_val         <= '0;
      setvl_req      <= 1'b0;
      setvl_rd       <= '0;
      setvl_imm      <= '0;
    end else begin
      out_valid <= hdr_valid;
      rd_we     <= ev_apply & dest_hit;
      setvl_req <= ev_apply & fwd_hit;
      if (hdr_valid) begin
        reg_wide       <= pfx.reg_wide;
        pred_wide      <= pfx.pred_wide;
        has_vl_word    <= pfx.has_vl;
        reg_cnt        <= lay_rcnt;
        pred_cnt       <= lay_pcnt;
        instr_len_bits <= lay_len;
        reg_off_bits   <= lay_roff;
        pred_off_bits  <= lay_poff;
        op_off_hw      <= lay_ophw;
        illegal        <= ev_illegal;
      end
      if (ev_apply) begin
        vl        <= nxt_vl;
        mvl       <= nxt_mvl;
        rd_num    <= dest_reg;
        rd_val    <= nxt_vl;
        setvl_rd  <= dest_reg;
        setvl_imm <= vw.imm;
      end
    end
  end
endmodule

// File: rtl/vblk_hdr_chk.sv
module vblk_hdr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hdr_valid,
  input logic       out_valid,
  input logic [3:0] reg_cnt,
  input logic [3:0] pred_cnt,
  input logic [7:0] instr_len_bits,
  input logic [4:0] op_off_hw,
  input logic       illegal,
  input logic [9:0] vl,
  input logic [9:0] mvl,
  input logic       rd_we,
  input logic [4:0] rd_num,
  input logic [9:0] rd_val,
  input logic       setvl_req
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) hdr_valid |=> out_valid); // R13
  AST_VALID_ONLY_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n) !hdr_valid |=> !out_valid); // R13
  AST_PRED_NOT_ABOVE_REG: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> pred_cnt <= reg_cnt); // R2
  AST_OPS_FIT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !illegal) |-> (8'(op_off_hw) <= (instr_len_bits >> 4))); // R6
  AST_VL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) vl <= mvl); // R7
  AST_DEST_WRITE_OK: assert property (@(posedge clk) disable iff (!rst_n) rd_we |-> (out_valid && !illegal && rd_num >= 5'd9 && rd_val <= mvl)); // R9
  AST_FWD_KEEPS_VL: assert property (@(posedge clk) disable iff (!rst_n) setvl_req |-> ($stable(vl) && $stable(mvl) && !rd_we)); // R10
  AST_ILLEGAL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && illegal) |-> ($stable(vl) && $stable(mvl) && !rd_we && !setvl_req)); // R12
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> ($stable(vl) && $stable(mvl) && !rd_we && !setvl_req)); // R13
endmodule

bind vblk_hdr_decode vblk_hdr_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hdr_valid      (hdr_valid),
  .out_valid      (out_valid),
  .reg_cnt        (reg_cnt),
  .pred_cnt       (pred_cnt),
  .instr_len_bits (instr_len_bits),
  .op_off_hw      (op_off_hw),
  .illegal        (illegal),
  .vl             (vl),
  .mvl            (mvl),
  .rd_we          (rd_we),
  .rd_num         (rd_num),
  .rd_val         (rd_val),
  .setvl_req      (setvl_req)
);

// File: tb/test_vblk_hdr_decode.sv
`timescale 1ns/1ps
module test_vblk_hdr_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic [8:0] prefix_hi = '0;
  logic [15:0] vl_word = '0;
  logic out_valid, reg_wide, pred_wide, has_vl_word, illegal, rd_we, setvl_req;
  logic [3:0] reg_cnt, pred_cnt;
  logic [7:0] instr_len_bits;
  logic [8:0] reg_off_bits, pred_off_bits;
  logic [4:0] op_off_hw, rd_num, setvl_rd;
  logic [9:0] vl, mvl, rd_val, setvl_imm;

  int n_checks = 0;
  int n_fail = 0;
  int m_vl = 0;
  int m_mvl = 64;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vblk_hdr_decode i_vblk_hdr_decode (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .prefix_hi(prefix_hi), .vl_word(vl_word),
    .out_valid(out_valid), .reg_wide(reg_wide), .pred_wide(pred_wide), .has_vl_word(has_vl_word),
    .reg_cnt(reg_cnt), .pred_cnt(pred_cnt), .instr_len_bits(instr_len_bits),
    .reg_off_bits(reg_off_bits), .pred_off_bits(pred_off_bits), .op_off_hw(op_off_hw),
    .illegal(illegal), .vl(vl), .mvl(mvl), .rd_we(rd_we), .rd_num(rd_num), .rd_val(rd_val),
    .setvl_req(setvl_req), .setvl_rd(setvl_rd), .setvl_imm(setvl_imm)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_rcnt(input bit wide, input int code);
    int tw[4] = '{0, 1, 2, 4};
    int tn[4] = '{0, 2, 4, 8};
    return wide ? tw[code] : tn[code];
  endfunction

  // generic run: drive one header, check every output against the model
  task automatic run(input logic [15:0] pfx, input logic [15:0] vw);
    bit rw, pw, full, hv, ill, upd;
    int code, il, rc, pc, roff, poff, endb, ophw, len, mode, dest, imm, dnum, nvl, nmvl;
    rw = pfx[7]; pw = pfx[8]; full = pfx[9]; code = int'(pfx[11:10]);
    il = int'(pfx[14:12]); hv = pfx[15];
    mode = int'(vw[15:14]); dest = int'(vw[13:10]); imm = int'(vw[9:0]);
    rc = m_rcnt(rw, code);
    pc = full ? rc : (rc / 2 + rc % 2);
    roff = hv ? 32 : 16;
    poff = roff + rc * (rw ? 16 : 8);
    endb = poff + pc * (pw ? 16 : 8);
    ophw = (endb + 15) / 16;
    len = 80 + 16 * il;
    ill = (ophw * 16 > len) || (hv && mode == 3 && vw[13:0] != 14'd0);
    upd = hv && !ill;
    dnum = (dest == 0) ? 0 : dest + 8;
    nvl = m_vl; nmvl = m_mvl;
    if (upd && mode == 0) nvl = (imm > m_mvl) ? m_mvl : imm;
    if (upd && mode == 2) begin nvl = imm; nmvl = imm; end
    @(negedge clk);
    prefix_hi = pfx[15:7];
    vl_word = vw;
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    check("R13 out_valid", int'(out_valid), 1);
    check("R1 reg_cnt", int'(reg_cnt), rc);
    check("R1 reg_wide", int'(reg_wide), int'(rw));
    check("R2 pred_cnt", int'(pred_cnt), pc);
    check("R2 pred_wide", int'(pred_wide), int'(pw));
    check("R3 has_vl_word", int'(has_vl_word), int'(hv));
    check("R3 reg_off_bits", int'(reg_off_bits), roff);
    check("R3 pred_off_bits", int'(pred_off_bits), poff);
    check("R4 op_off_hw", int'(op_off_hw), ophw);
    check("R5 instr_len_bits", int'(instr_len_bits), len);
    check("R6 R11 illegal", int'(illegal), int'(ill));
    check("R7 R8 R12 vl", int'(vl), nvl);
    check("R8 R12 mvl", int'(mvl), nmvl);
    check("R9 R12 rd_we", int'(rd_we), int'(upd && (mode == 0 || mode == 2) && dest != 0));
    if (upd && (mode == 0 || mode == 2) && dest != 0) begin
      check("R9 rd_num", int'(rd_num), dnum);
      check("R9 rd_val", int'(rd_val), nvl);
    end
    check("R10 R12 setvl_req", int'(setvl_req), int'(upd && mode == 1));
    if (upd && mode == 1) begin
      check("R10 setvl_rd", int'(setvl_rd), dnum);
      check("R10 setvl_imm", int'(setvl_imm), imm);
    end
    m_vl = nvl; m_mvl = nmvl;
    @(negedge clk);
    check("R13 out_valid pulse", int'(out_valid), 0);
    check("R13 rd_we pulse", int'(rd_we), 0);
    check("R13 setvl_req pulse", int'(setvl_req), 0);
    check("R13 vl held", int'(vl), m_vl);
  endtask

  task automatic t_reset();
    check("R13 reset out_valid", int'(out_valid), 0);
    check("R13 reset vl", int'(vl), 0);
    check("R13 reset mvl", int'(mvl), 64);
    check("R13 reset rd_we", int'(rd_we), 0);
    check("R13 reset setvl_req", int'(setvl_req), 0);
  endtask

  task automatic t_layout_sweep();  // R1 R2 R3 R4 R5 R6
    for (int p = 0; p < 512; p++) begin
      logic [15:0] pf;
      logic [15:0] vw;
      pf = {p[5], p[8:6], p[2:1], p[3], p[4], p[0], 7'h3F};
      vw = {2'b00, 4'(p % 16), 10'(p * 3)};
      run(pf, vw);
    end
  endtask

  task automatic t_mode_both();  // R8 R9
    run(16'h8000, {2'b10, 4'd3, 10'd100});
    run(16'h8000, {2'b10, 4'd0, 10'd200});
    run(16'h8000, {2'b10, 4'd1, 10'd100});
  endtask

  task automatic t_mode_clamp();  // R7 R9
    run(16'h8000, {2'b00, 4'd0, 10'd40});
    run(16'h8000, {2'b00, 4'd15, 10'd500});
    run(16'h8000, {2'b00, 4'd2, 10'd100});
  endtask

  task automatic t_mode_fwd();  // R10
    run(16'h8000, {2'b01, 4'd5, 10'd300});
    run(16'h8000, {2'b01, 4'd0, 10'd7});
  endtask

  task automatic t_mode_rsvd();  // R11
    run(16'h8000, 16'hC000);
    run(16'h8000, 16'hC001);
    run(16'h8000, 16'hC400);
  endtask

  task automatic t_fit_edge();  // R6 R12
    run(16'hDF80, {2'b10, 4'd4, 10'd7});
    run(16'hCF80, {2'b10, 4'd4, 10'd9});
  endtask

  task automatic t_no_vl_word();  // R12
    run(16'h0000, {2'b10, 4'd6, 10'd5});
    run(16'h7000, {2'b01, 4'd6, 10'd5});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R13 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_both();
    t_mode_clamp();
    t_mode_fwd();
    t_mode_rsvd();
    t_fit_edge();
    t_no_vl_word();
    t_layout_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule